// File: doc/BRIEF.md
# Sector Test-Pattern Generator and Checker

This block produces the data for a storage write test and checks the data that comes back on the later read. Each run covers a span of consecutive 512-byte sectors. The span begins at a start LBA and has a given sector count. In write mode the block streams 32-bit words with a valid/ready handshake. In read mode it takes 32-bit words, regenerates the word each one should be, and compares the two.

Every sector opens with a two-word header that holds the sector's 48-bit LBA, so no two sectors carry the same data. The remaining 126 words carry one of five fill patterns. The fill sequence is seeded from the start LBA and runs on across sector boundaries without restarting. A read run therefore has to be configured with the same start LBA and pattern as the write run it checks.

A mismatch raises a sticky error flag and keeps the first failing pair of words. It also increments a count of bad words. Comparison goes on to the end of the run. A one-cycle done pulse closes each run.

Top module: `spg_top`

## Requirements
- R1: A sector is 128 words. Word 0 is LBA bits 31:0. Word 1 holds LBA bits 47:32 in bits 15:0, with bits 31:16 zero. Words 2 to 127 are fill words.
- R2: The header LBA of the first sector is the start LBA. Each following sector's header LBA is one greater, with full 48-bit carry.
- R3: patSel 0 gives an incrementing fill and 1 a decrementing fill, each seeded with start LBA bits 31:0. patSel 2 gives all zeros and 3 gives all ones. The fill value steps only on fill words and carries on across sectors.
- R4: patSel 4 selects an LFSR fill. Each step shifts the register left one place and sets bit 0 to the XOR of bits 31, 21, 1 and 0. The seed is start LBA bits 31:0, and a zero seed becomes 1.
- R5: In write mode wrValid is high during the run. A word advances only on a cycle where wrValid and wrReady are both high. While wrReady is low, wrData holds its value. rdReady stays low in write mode.
- R6: In read mode rdReady is high during the run, and a word is taken when rdValid is high. The first mismatching word raises errFlag on the next cycle. errRead and errExpect then hold the received and expected words of that first mismatch until the next accepted start clears them.
- R7: errCount is the total number of mismatching words in the run, and it is cleared by an accepted start.
- R8: busy rises the cycle after an accepted start. It falls, and done pulses for one cycle, the cycle after the handshake of the last word of the last sector.
- R9: A start with patSel 5 to 7 or a sector count of zero sets invalidCfg and does not set busy. invalidCfg clears on the next accepted start.
- R10: A start while busy is ignored. The run in progress continues with its original settings, and invalidCfg is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, sampled when idle |
| writeMode | input | 1 | 1 = generate write stream, 0 = check read stream |
| startLba | input | 48 | First sector address of the run |
| sectorCount | input | 16 | Number of sectors in the run |
| patSel | input | 3 | Fill pattern select |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| invalidCfg | output | 1 | Last idle start was rejected |
| wrData | output | 32 | Generated word |
| wrValid | output | 1 | Generated word is valid |
| wrReady | input | 1 | Sink accepts generated word |
| rdData | input | 32 | Word read back from storage |
| rdValid | input | 1 | Read word is valid |
| rdReady | output | 1 | Block accepts read words |
| errFlag | output | 1 | At least one mismatch in this run |
| errRead | output | 32 | Received word of first mismatch |
| errExpect | output | 32 | Expected word of first mismatch |
| errCount | output | 16 | Number of mismatching words |

## Verification
wrData is valid in the same cycle as wrValid. It is checked on each negative edge against a model word that advances only after a handshake edge. errFlag, errRead, errExpect and errCount change one edge after the bad word is taken, so they are read only after the run has finished. busy rises, and invalidCfg moves, one edge after start. done is read at the first negative edge after the final handshake, and its absence is checked one cycle later. Stall patterns on wrReady and rdValid exercise the hold rule and show that progress follows only handshakes.

// File: rtl/spg_pkg.sv
package spg_pkg;

  typedef enum logic [2:0] {
    PAT_INC  = 3'd0,
    PAT_DEC  = 3'd1,
    PAT_ZERO = 3'd2,
    PAT_ONE  = 3'd3,
    PAT_LFSR = 3'd4
  } pat_e;

  localparam logic [2:0] PAT_LAST = 3'd4;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // accepted start
    logic beat;       // word handshake
    logic check;      // beat in read mode
    logic hdrLo;      // current word is header word 0
    logic hdrHi;      // current word is header word 1
    logic sectorEnd;  // beat on last word of a sector
  } strobe_t;

  function automatic logic [31:0] lfsrStep(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

endpackage

// File: rtl/spg_ctrl.sv
module spg_ctrl
  import spg_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int SECTOR_WORDS = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             writeMode,
  input  logic [2:0]       patSel,
  input  logic [CNT_W-1:0] sectorCount,
  input  logic             wrReady,
  input  logic             rdValid,
  output logic             busy,
  output logic             done,
  output logic             invalidCfg,
  output logic             wrValid,
  output logic             rdReady,
  output strobe_t          strb
);
  localparam int IDX_W = $clog2(SECTOR_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECTOR_WORDS - 1);

  logic             isWrite;
  logic [IDX_W-1:0] wordIdx;
  logic [CNT_W-1:0] secLeft;
  logic             cfgOk, accept, reject, beat, lastWord;

  assign cfgOk    = (patSel <= PAT_LAST) && (sectorCount != '0);
  assign accept   = start && !busy && cfgOk;
  assign reject   = start && !busy && !cfgOk;
  assign wrValid  = busy && isWrite;
  assign rdReady  = busy && !isWrite;
  assign beat     = busy && (isWrite ? wrReady : rdValid);
  assign lastWord = (wordIdx == LAST_IDX);

  always_comb begin
    strb.load      = accept;
    strb.beat      = beat;
    strb.check     = beat && !isWrite;
    strb.hdrLo     = (wordIdx == IDX_W'(0));
    strb.hdrHi     = (wordIdx == IDX_W'(1));
    strb.sectorEnd = beat && lastWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      invalidCfg <= 1'b0;
      isWrite    <= 1'b0;
      wordIdx    <= '0;
      secLeft    <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy       <= 1'b1;
        isWrite    <= writeMode;
        wordIdx    <= '0;
        secLeft    <= sectorCount;
        invalidCfg <= 1'b0;
      end else if (reject) begin
        invalidCfg <= 1'b1;
      end
      if (beat) begin
        wordIdx <= lastWord ? '0 : wordIdx + 1'b1;
        if (lastWord) begin
          secLeft <= secLeft - 1'b1;
          if (secLeft == CNT_W'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spg_datapath.sv
module spg_datapath
  import spg_pkg::*;
#(
  parameter int LBA_W    = 48,
  parameter int ERRCNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [LBA_W-1:0]    startLba,
  input  logic [2:0]          patSel,
  input  logic [31:0]         rdData,
  output logic [31:0]         expWord,
  output logic                errFlag,
  output logic [31:0]         errRead,
  output logic [31:0]         errExpect,
  output logic [ERRCNT_W-1:0] errCount
);
  localparam int HDR_W = 64;

  logic [LBA_W-1:0] lba;
  logic [31:0]      fill, fillWord, seed;
  logic [2:0]       pat;
  logic [HDR_W-1:0] hdr;
  logic             mismatch;

  assign hdr  = HDR_W'(lba);
  assign seed = ((patSel == PAT_LFSR) && (startLba[31:0] == '0)) ? 32'd1 : startLba[31:0];

  always_comb begin
    case (pat)
      PAT_ZERO: fillWord = '0;
      PAT_ONE:  fillWord = '1;
      default:  fillWord = fill;
    endcase
    if (strb.hdrLo)      expWord = hdr[31:0];
    else if (strb.hdrHi) expWord = hdr[63:32];
    else                 expWord = fillWord;
  end

  assign mismatch = strb.check && (rdData != expWord);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lba       <= '0;
      fill      <= '0;
      pat       <= '0;
      errFlag   <= 1'b0;
      errRead   <= '0;
      errExpect <= '0;
      errCount  <= '0;
    end else if (strb.load) begin
      lba       <= startLba;
      fill      <= seed;
      pat       <= patSel;
      errFlag   <= 1'b0;
      errRead   <= '0;
      errExpect <= '0;
      errCount  <= '0;
    end else begin
      if (strb.beat && !strb.hdrLo && !strb.hdrHi) begin
        case (pat)
          PAT_INC:  fill <= fill + 32'd1;
          PAT_DEC:  fill <= fill - 32'd1;
          PAT_LFSR: fill <= lfsrStep(fill);
          default:  fill <= fill;
        endcase
      end
      if (strb.sectorEnd) lba <= lba + 1'b1;
      if (mismatch) begin
        errFlag <= 1'b1;
        if (errCount != '1) errCount <= errCount + 1'b1;
        if (!errFlag) begin
          errRead   <= rdData;
          errExpect <= expWord;
        end
      end
    end
  end
endmodule

// File: rtl/spg_top.sv
module spg_top
  import spg_pkg::*;
#(
  parameter int LBA_W        = 48,
  parameter int CNT_W        = 16,
  parameter int ERRCNT_W     = 16,
  parameter int SECTOR_WORDS = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                writeMode,
  input  logic [LBA_W-1:0]    startLba,
  input  logic [CNT_W-1:0]    sectorCount,
  input  logic [2:0]          patSel,
  output logic                busy,
  output logic                done,
  output logic                invalidCfg,
  output logic [31:0]         wrData,
  output logic                wrValid,
  input  logic                wrReady,
  input  logic [31:0]         rdData,
  input  logic                rdValid,
  output logic                rdReady,
  output logic                errFlag,
  output logic [31:0]         errRead,
  output logic [31:0]         errExpect,
  output logic [ERRCNT_W-1:0] errCount
);
  strobe_t strb;

  spg_ctrl #(.CNT_W(CNT_W), .SECTOR_WORDS(SECTOR_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .writeMode(writeMode),
    .patSel(patSel), .sectorCount(sectorCount), .wrReady(wrReady),
    .rdValid(rdValid), .busy(busy), .done(done), .invalidCfg(invalidCfg),
    .wrValid(wrValid), .rdReady(rdReady), .strb(strb)
  );

  spg_datapath #(.LBA_W(LBA_W), .ERRCNT_W(ERRCNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .startLba(startLba),
    .patSel(patSel), .rdData(rdData), .expWord(wrData),
    .errFlag(errFlag), .errRead(errRead), .errExpect(errExpect),
    .errCount(errCount)
  );
endmodule

// File: rtl/spg_checker.sv
module spg_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [2:0]       patSel,
  input logic [CNT_W-1:0] sectorCount,
  input logic             busy,
  input logic             done,
  input logic             invalidCfg,
  input logic             wrValid,
  input logic             wrReady,
  input logic [31:0]      wrData,
  input logic             rdReady,
  input logic             errFlag,
  input logic [31:0]      errRead,
  input logic [31:0]      errExpect
);
  logic goodStart, badStart;
  assign goodStart = start && !busy && (patSel <= 3'd4) && (sectorCount != '0);
  assign badStart  = start && !busy && !((patSel <= 3'd4) && (sectorCount != '0));

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                            // R8
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));                           // R8
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    goodStart |=> (busy && !invalidCfg));                       // R9
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    badStart |=> (!busy && invalidCfg));                        // R9
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy && !invalidCfg) |=> !invalidCfg);            // R10
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrData)));    // R5
  AST_PATH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(wrValid && rdReady));                                     // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !goodStart) |=> (errFlag && $stable(errRead) && $stable(errExpect))); // R6
endmodule

bind spg_top spg_checker u_chk (
  .clk(clk), .rstN(rstN), .start(start), .patSel(patSel),
  .sectorCount(sectorCount), .busy(busy), .done(done),
  .invalidCfg(invalidCfg), .wrValid(wrValid), .wrReady(wrReady),
  .wrData(wrData), .rdReady(rdReady), .errFlag(errFlag),
  .errRead(errRead), .errExpect(errExpect)
);

// File: tb/sim_spg_top.sv
`timescale 1ns/1ps
module sim_spg_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        writeMode = 1'b0;
  logic [47:0] startLba = '0;
  logic [15:0] sectorCount = '0;
  logic [2:0]  patSel = '0;
  logic        wrReady = 1'b0;
  logic [31:0] rdData = '0;
  logic        rdValid = 1'b0;
  logic        busy, done, invalidCfg, wrValid, rdReady, errFlag;
  logic [31:0] wrData, errRead, errExpect;
  logic [15:0] errCount;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  spg_top u0 (
    .clk(clk), .rstN(rstN), .start(start), .writeMode(writeMode),
    .startLba(startLba), .sectorCount(sectorCount), .patSel(patSel),
    .busy(busy), .done(done), .invalidCfg(invalidCfg), .wrData(wrData),
    .wrValid(wrValid), .wrReady(wrReady), .rdData(rdData),
    .rdValid(rdValid), .rdReady(rdReady), .errFlag(errFlag),
    .errRead(errRead), .errExpect(errExpect), .errCount(errCount)
  );

  // Reference model of the expected stream
  logic [47:0] mLba;
  logic [31:0] mFill;
  logic [2:0]  mPat;
  int          mIdx;

  function automatic void mInit(input logic [47:0] lba, input logic [2:0] pat);
    mLba  = lba;
    mPat  = pat;
    mIdx  = 0;
    mFill = (pat == 3'd4 && lba[31:0] == 32'd0) ? 32'd1 : lba[31:0];
  endfunction

  function automatic logic [31:0] mPeek();
    if (mIdx == 0) return mLba[31:0];
    if (mIdx == 1) return {16'h0000, mLba[47:32]};
    case (mPat)
      3'd2:    return 32'h0000_0000;
      3'd3:    return 32'hFFFF_FFFF;
      default: return mFill;
    endcase
  endfunction

  function automatic void mAdvance();
    if (mIdx >= 2) begin
      case (mPat)
        3'd0: mFill = mFill + 32'd1;
        3'd1: mFill = mFill - 32'd1;
        3'd4: mFill = {mFill[30:0], mFill[31] ^ mFill[21] ^ mFill[1] ^ mFill[0]};
        default: mFill = mFill;
      endcase
    end
    mIdx = mIdx + 1;
    if (mIdx == 128) begin
      mIdx = 0;
      mLba = mLba + 48'd1;
    end
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic startRun(input bit wm, input logic [47:0] lba,
                          input int cnt, input logic [2:0] pat);
    @(negedge clk);
    writeMode   = wm;
    startLba    = lba;
    sectorCount = 16'(cnt);
    patSel      = pat;
    start       = 1'b1;
    @(negedge clk);
    start       = 1'b0;
  endtask

  task automatic checkDone(input string req);
    chk(done === 1'b1 && busy === 1'b0, req, "done pulse / busy fall at end",
        {62'd0, done, busy}, 64'd2);
    @(negedge clk);
    chk(done === 1'b0, req, "done lasts one cycle", {63'd0, done}, 64'd0);
  endtask

  task automatic tReset();
    chk(busy === 1'b0 && done === 1'b0, "R8", "reset busy/done", {62'd0, busy, done}, 64'd0);
    chk(wrValid === 1'b0 && rdReady === 1'b0, "R5", "reset valid/ready", {62'd0, wrValid, rdReady}, 64'd0);
    chk(errFlag === 1'b0 && errCount === 16'd0, "R7", "reset error state", {47'd0, errFlag, errCount}, 64'd0);
    chk(invalidCfg === 1'b0, "R9", "reset invalidCfg", {63'd0, invalidCfg}, 64'd0);
  endtask

  // Write run; stallMode stalls wrReady, inject issues a start mid-run
  task automatic tWrite(input logic [47:0] lba, input int cnt, input logic [2:0] pat,
                        input bit stallMode, input bit inject, input string req);
    int beats = 0;
    int cyc = 0;
    int bad = 0;
    logic [31:0] badAct = '0;
    logic [31:0] badExp = '0;
    int total = cnt * 128;
    mInit(lba, pat);
    startRun(1'b1, lba, cnt, pat);
    chk(busy === 1'b1 && rdReady === 1'b0, "R8", "busy after start", {62'd0, busy, rdReady}, 64'd2);
    while (beats < total && cyc < total * 4) begin
      logic rdy = stallMode ? (cyc % 4 != 3) : 1'b1;
      wrReady = rdy;
      if (inject) begin
        start    = (cyc == 10);
        patSel   = (cyc == 10) ? 3'd7 : pat;
        startLba = (cyc == 10) ? 48'd999 : lba;
      end
      if (wrValid !== 1'b1 || wrData !== mPeek()) begin
        if (bad == 0) begin badAct = wrData; badExp = mPeek(); end
        bad++;
      end
      if (rdy) begin mAdvance(); beats++; end
      cyc++;
      @(negedge clk);
    end
    wrReady = 1'b0;
    start   = 1'b0;
    checkDone("R8");
    chk(bad == 0, req, "write stream first bad word", {32'd0, badAct}, {32'd0, badExp});
    if (inject)
      chk(invalidCfg === 1'b0, "R10", "start while busy left invalidCfg", {63'd0, invalidCfg}, 64'd0);
  endtask

  // Read run; words at beats c1..c3 are corrupted (negative = none)
  task automatic tRead(input logic [47:0] lba, input int cnt, input logic [2:0] pat,
                       input int c1, input int c2, input int c3);
    int beats = 0;
    int cyc = 0;
    int nBad = 0;
    int rdyBad = 0;
    logic [31:0] firstAct = '0;
    logic [31:0] firstExp = '0;
    int total = cnt * 128;
    mInit(lba, pat);
    startRun(1'b0, lba, cnt, pat);
    while (beats < total && cyc < total * 4) begin
      logic vld = (cyc % 3 != 1);
      logic [31:0] w = mPeek();
      if (beats == c1 || beats == c2 || beats == c3) w = w ^ 32'h0000_0100;
      rdValid = vld;
      rdData  = w;
      if (rdReady !== 1'b1 || wrValid !== 1'b0) rdyBad++;
      if (vld) begin
        if (w != mPeek()) begin
          if (nBad == 0) begin firstAct = w; firstExp = mPeek(); end
          nBad++;
        end
        mAdvance();
        beats++;
      end
      cyc++;
      @(negedge clk);
    end
    rdValid = 1'b0;
    checkDone("R8");
    chk(rdyBad == 0, "R6", "rdReady high through read run", 64'(rdyBad), 64'd0);
    chk(errFlag === (nBad != 0), "R6", "errFlag after read", {63'd0, errFlag}, {63'd0, nBad != 0});
    chk(errCount === 16'(nBad), "R7", "mismatch count", {48'd0, errCount}, 64'(nBad));
    chk(errRead === firstAct && errExpect === firstExp, "R6", "first mismatch pair",
        {errRead, errExpect}, {firstAct, firstExp});
  endtask

  task automatic tInvalid();
    startRun(1'b1, 48'd10, 2, 3'd6);
    chk(invalidCfg === 1'b1 && busy === 1'b0, "R9", "pattern 6 rejected",
        {62'd0, invalidCfg, busy}, 64'd2);
    @(negedge clk);
    chk(busy === 1'b0 && wrValid === 1'b0, "R9", "no run after reject", {62'd0, busy, wrValid}, 64'd0);
    startRun(1'b1, 48'd10, 0, 3'd0);
    chk(invalidCfg === 1'b1 && busy === 1'b0, "R9", "zero count rejected",
        {62'd0, invalidCfg, busy}, 64'd2);
  endtask

  initial begin
    #(5.0 * 60000);
    fails++;
    $display("FAIL R8 watchdog expired actual=%0d expected=0", tests);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tWrite(48'd5, 2, 3'd0, 1'b0, 1'b0, "R1 R2 R3 increment");
    tWrite(48'h1_FFFF_FFFF, 2, 3'd1, 1'b1, 1'b0, "R2 R3 R5 decrement carry stall");
    tWrite(48'd40, 1, 3'd2, 1'b1, 1'b0, "R3 zeros");
    tWrite(48'd41, 1, 3'd3, 1'b0, 1'b0, "R3 ones");
    tWrite(48'd0, 2, 3'd4, 1'b1, 1'b0, "R4 lfsr zero seed");
    tRead(48'h0000_1234_5678, 2, 3'd0, 1, 130, 200);
    tRead(48'd77, 2, 3'd4, -1, -1, -1);
    tInvalid();
    tWrite(48'd100, 1, 3'd0, 1'b0, 1'b1, "R10 R9 start ignored while busy");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule